// File: doc/BRIEF.md
# Multi-Bank Row Buffer Array with In-Bank Row Copy

This block models a multi-bank dynamic memory array at the row level and adds a sequencer that duplicates one row into another row of the same bank. No data crosses the external data path. Each bank keeps a row store and a single row buffer. A command port accepts open-row, column read, column write and close-row operations. Every command is answered by a registered response one cycle later. An open-row command given while another row already sits latched in the buffer does not load anything. Instead, the buffer contents are driven into the newly selected row, so two opens in a row clone data.

A separate copy request port takes a bank number, a source row and a destination row through a ready/valid handshake. The copy engine of that bank first closes the bank. It then opens the source row and waits a programmable gap. Next it opens the destination row while the buffer still holds the source data, waits a programmable settling interval, and closes the bank again. The bank reports busy for the whole sequence and then pulses done for one cycle. While it is busy, the bank refuses external commands, and the other banks keep working.

Top module: `rowcopy_array`

## Requirements
- R1: After reset no bank is busy, copy_done is low, rsp_valid is low, and every row buffer is closed, so a column read to any bank is refused.
- R2: Command codes are 0 open, 1 read, 2 write and 3 close. The response to a command arrives on the next cycle with rsp_valid high. An open on a closed bank loads the named row into the buffer, and a following read of that row returns the word at the given column with rsp_ok and rsp_hit high.
- R3: A read or write whose row is not the open row, or that targets a closed bank, is refused with rsp_ok, rsp_hit and rsp_rdata all zero, and a refused write changes no stored data.
- R4: An open naming the row that is already open is a hit: rsp_ok and rsp_hit are high and neither the buffer nor the array changes.
- R5: An open naming a different row while the buffer is open writes the whole buffer into that row and makes it the open row. The buffer keeps its data.
- R6: A close is always accepted on an idle bank and closes the buffer.
- R7: req_ready equals the inverse of copy_busy for the bank on req_bank. An accepted request raises that bank's copy_busy on the next cycle for exactly 4 + GAP_CYC + SET_CYC cycles. copy_done pulses for one cycle in the first cycle that busy is low again, and a request held against a busy bank is not taken.
- R8: After a copy, the destination row equals the source row, every other row of every bank is unchanged, and the bank's buffer is closed.
- R9: A copy whose source and destination are the same row leaves all data unchanged.
- R10: While a bank is copying, every command to it is refused with rsp_ok low, and commands to other banks are served normally.
- R11: Banks are independent. Opening, writing or closing one bank does not change another bank's buffer or rows, and two banks can copy at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 open, 1 read, 2 write, 3 close |
| cmd_bank | input | BANK_W | Target bank |
| cmd_row | input | ROW_AW | Row address |
| cmd_col | input | COL_AW | Column word within the row |
| cmd_wdata | input | WORD_W | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's command |
| rsp_ok | output | 1 | Command was carried out |
| rsp_hit | output | 1 | Addressed row was already open |
| rsp_rdata | output | WORD_W | Read word, zero otherwise |
| req_valid | input | 1 | Copy request present |
| req_ready | output | 1 | Addressed bank can take a copy |
| req_bank | input | BANK_W | Copy bank |
| req_src | input | ROW_AW | Copy source row |
| req_dst | input | ROW_AW | Copy destination row |
| copy_busy | output | NUM_BANKS | Per-bank copy in progress |
| copy_done | output | NUM_BANKS | Per-bank one-cycle completion pulse |

## Verification
The bench builds the block with two banks of eight rows, each four 8-bit words wide, and a gap of 2 and a settle of 3 cycles, which gives a 9-cycle busy window. That window is short enough to refuse a command, serve the other bank, stall a request and start a second copy on the other bank inside one copy. Eight rows per bank are few enough that every row of both banks can be read back after each copy. Two banks are enough to show overlap and independence.

// File: rtl/rc_pkg.sv
package rc_pkg;
  typedef enum logic [1:0] {
    OP_OPEN  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2,
    OP_CLOSE = 2'd3
  } rc_op_e;
endpackage

// File: rtl/rc_bank.sv
module rc_bank
  import rc_pkg::*;
#(
  parameter int ROWS   = 8,
  parameter int COLS   = 4,
  parameter int WORD_W = 8,
  localparam int RA_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CA_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ROW_W = COLS * WORD_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_en,
  input  rc_op_e           op,
  input  logic [RA_W-1:0]  row,
  input  logic [CA_W-1:0]  col,
  input  logic [WORD_W-1:0] wdata,
  output logic             hit,
  output logic [ROW_W-1:0] row_buf
);
  logic [ROW_W-1:0] mem [ROWS];
  logic [ROW_W-1:0] latch_q;
  logic             open_vld_q;
  logic [RA_W-1:0]  open_row_q;
  logic [ROW_W-1:0] merged;
  logic             mem_we;
  logic [RA_W-1:0]  mem_wa;
  logic [ROW_W-1:0] mem_wd;

  assign hit     = open_vld_q && (open_row_q == row);
  assign row_buf = latch_q;

  always_comb begin
    merged = latch_q;
    merged[col*WORD_W +: WORD_W] = wdata;
  end

  // single write port: clone on open-over-latched, or write-through on hit
  always_comb begin
    mem_we = 1'b0;
    mem_wa = row;
    mem_wd = latch_q;
    if (op_en) begin
      case (op)
        OP_OPEN:  if (open_vld_q && !hit) mem_we = 1'b1;
        OP_WRITE: if (hit) begin
          mem_we = 1'b1;
          mem_wa = open_row_q;
          mem_wd = merged;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= mem_wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q    <= '0;
      open_vld_q <= 1'b0;
      open_row_q <= '0;
    end else if (op_en) begin
      case (op)
        OP_OPEN: begin
          if (!open_vld_q) begin
            latch_q    <= mem[row];
            open_vld_q <= 1'b1;
            open_row_q <= row;
          end else if (!hit) begin
            open_row_q <= row;
          end
        end
        OP_WRITE: if (hit) latch_q <= merged;
        OP_CLOSE: open_vld_q <= 1'b0;
        default: ;
      endcase
    end
  end

  a_r2_open_loads: assert property (@(posedge clk) disable iff (rst)
    op_en && op == OP_OPEN && !open_vld_q |=> open_vld_q && open_row_q == $past(row));
  a_r6_close_clears: assert property (@(posedge clk) disable iff (rst)
    op_en && op == OP_CLOSE |=> !open_vld_q);
  a_r5_clone_keeps_latch: assert property (@(posedge clk) disable iff (rst)
    op_en && op == OP_OPEN && open_vld_q |=> $stable(latch_q) && open_vld_q);
  a_r3_miss_write_inert: assert property (@(posedge clk) disable iff (rst)
    op_en && op == OP_WRITE && !hit |=> $stable(latch_q));
endmodule

// File: rtl/rc_copy_seq.sv
module rc_copy_seq
  import rc_pkg::*;
#(
  parameter int ROWS    = 8,
  parameter int GAP_CYC = 2,
  parameter int SET_CYC = 3,
  localparam int RA_W   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int MAXW   = (GAP_CYC > SET_CYC) ? GAP_CYC : SET_CYC,
  localparam int CNT_W  = $clog2(MAXW + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [RA_W-1:0] src,
  input  logic [RA_W-1:0] dst,
  output logic            busy,
  output logic            done,
  output logic            issue_en,
  output rc_op_e          issue_op,
  output logic [RA_W-1:0] issue_row
);
  typedef enum logic [2:0] {
    S_IDLE, S_CLOSE0, S_OPEN_SRC, S_GAP, S_OPEN_DST, S_SETTLE, S_CLOSE1
  } seq_e;

  seq_e             st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RA_W-1:0]  src_q, dst_q;

  always_comb begin
    issue_en  = 1'b0;
    issue_op  = OP_CLOSE;
    issue_row = src_q;
    case (st_q)
      S_CLOSE0, S_CLOSE1: issue_en = 1'b1;
      S_OPEN_SRC: begin issue_en = 1'b1; issue_op = OP_OPEN; end
      S_OPEN_DST: begin issue_en = 1'b1; issue_op = OP_OPEN; issue_row = dst_q; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      src_q <= '0;
      dst_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          st_q  <= S_CLOSE0;
          src_q <= src;
          dst_q <= dst;
          busy  <= 1'b1;
        end
        S_CLOSE0:   st_q <= S_OPEN_SRC;
        S_OPEN_SRC: begin st_q <= S_GAP; cnt_q <= '0; end
        S_GAP: begin
          if (cnt_q == CNT_W'(GAP_CYC - 1)) st_q <= S_OPEN_DST;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_OPEN_DST: begin st_q <= S_SETTLE; cnt_q <= '0; end
        S_SETTLE: begin
          if (cnt_q == CNT_W'(SET_CYC - 1)) st_q <= S_CLOSE1;
          else cnt_q <= cnt_q + 1'b1;
        end
        S_CLOSE1: begin
          st_q <= S_IDLE;
          busy <= 1'b0;
          done <= 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  a_r7_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r7_busy_fall_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  a_r7_start_raises_busy: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
endmodule

// File: rtl/rowcopy_array.sv
module rowcopy_array
  import rc_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ROWS      = 8,
  parameter int COLS      = 4,
  parameter int WORD_W    = 8,
  parameter int GAP_CYC   = 2,
  parameter int SET_CYC   = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ROW_AW   = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int COL_AW   = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ROW_W    = COLS * WORD_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  input  logic [1:0]           cmd_op,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [ROW_AW-1:0]    cmd_row,
  input  logic [COL_AW-1:0]    cmd_col,
  input  logic [WORD_W-1:0]    cmd_wdata,
  output logic                 rsp_valid,
  output logic                 rsp_ok,
  output logic                 rsp_hit,
  output logic [WORD_W-1:0]    rsp_rdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [ROW_AW-1:0]    req_src,
  input  logic [ROW_AW-1:0]    req_dst,
  output logic [NUM_BANKS-1:0] copy_busy,
  output logic [NUM_BANKS-1:0] copy_done
);
  rc_op_e           op;
  logic             bank_hit [NUM_BANKS];
  logic [ROW_W-1:0] bank_row [NUM_BANKS];
  logic             sel_ok, sel_hit, in_range, req_range;
  logic [WORD_W-1:0] sel_data;

  assign op        = rc_op_e'(cmd_op);
  assign in_range  = 32'(cmd_bank) < NUM_BANKS;
  assign req_range = 32'(req_bank) < NUM_BANKS;
  assign req_ready = req_range && !copy_busy[req_bank];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic            ext_sel, start, s_busy, s_done, s_en;
    rc_op_e          s_op;
    logic [ROW_AW-1:0] s_row;
    logic            b_en;
    rc_op_e          b_op;
    logic [ROW_AW-1:0] b_row;

    assign ext_sel = cmd_valid && (cmd_bank == BANK_W'(b));
    assign start   = req_valid && req_ready && (req_bank == BANK_W'(b));

    rc_copy_seq #(.ROWS(ROWS), .GAP_CYC(GAP_CYC), .SET_CYC(SET_CYC)) u_seq (
      .clk(clk), .rst(rst), .start(start), .src(req_src), .dst(req_dst),
      .busy(s_busy), .done(s_done), .issue_en(s_en), .issue_op(s_op),
      .issue_row(s_row)
    );

    // sequencer owns the bank for the whole copy
    assign b_en  = s_busy ? s_en  : ext_sel;
    assign b_op  = s_busy ? s_op  : op;
    assign b_row = s_busy ? s_row : cmd_row;

    rc_bank #(.ROWS(ROWS), .COLS(COLS), .WORD_W(WORD_W)) u_bank (
      .clk(clk), .rst(rst), .op_en(b_en), .op(b_op), .row(b_row),
      .col(cmd_col), .wdata(cmd_wdata), .hit(bank_hit[b]), .row_buf(bank_row[b])
    );

    assign copy_busy[b] = s_busy;
    assign copy_done[b] = s_done;
  end

  always_comb begin
    sel_ok   = 1'b0;
    sel_hit  = 1'b0;
    sel_data = '0;
    if (in_range && !copy_busy[cmd_bank]) begin
      case (op)
        OP_OPEN:  begin sel_ok = 1'b1; sel_hit = bank_hit[cmd_bank]; end
        OP_CLOSE: sel_ok = 1'b1;
        OP_READ:  if (bank_hit[cmd_bank]) begin
          sel_ok   = 1'b1;
          sel_hit  = 1'b1;
          sel_data = bank_row[cmd_bank][cmd_col*WORD_W +: WORD_W];
        end
        OP_WRITE: if (bank_hit[cmd_bank]) begin sel_ok = 1'b1; sel_hit = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cmd_valid;
      rsp_ok    <= cmd_valid && sel_ok;
      rsp_hit   <= cmd_valid && sel_hit;
      rsp_rdata <= cmd_valid ? sel_data : '0;
    end
  end

  a_r10_busy_refuse: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && in_range && copy_busy[cmd_bank] |=> rsp_valid && !rsp_ok);
  a_r7_accept_busy: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> copy_busy[$past(req_bank)]);
  a_r2_rsp_follows_cmd: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> rsp_valid);
  a_r3_idle_rsp_quiet: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> !rsp_valid && !rsp_ok && !rsp_hit);
endmodule

// File: tb/tb_rowcopy_array.sv
module tb_rowcopy_array;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 2, ROWS = 8, COLS = 4, WW = 8, GAP = 2, SET = 3;
  localparam int LAT = 4 + GAP + SET;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [0:0] cmd_bank = '0, req_bank = '0;
  logic [2:0] cmd_row = '0, req_src = '0, req_dst = '0;
  logic [1:0] cmd_col = '0;
  logic [WW-1:0] cmd_wdata = '0;
  logic req_valid = 1'b0;
  logic rsp_valid, rsp_ok, rsp_hit, req_ready;
  logic [WW-1:0] rsp_rdata;
  logic [NB-1:0] copy_busy, copy_done;

  rowcopy_array #(.NUM_BANKS(NB), .ROWS(ROWS), .COLS(COLS), .WORD_W(WW),
                  .GAP_CYC(GAP), .SET_CYC(SET)) dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
    .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_bank(req_bank), .req_src(req_src),
    .req_dst(req_dst), .copy_busy(copy_busy), .copy_done(copy_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0;
  string tag = "R1";
  bit started = 0;

  // reference model state
  int m_mem [NB][ROWS][COLS];
  int m_buf [NB][COLS];
  bit m_val [NB];
  int m_open [NB];
  int m_cnt [NB];
  int m_src [NB], m_dst [NB];
  bit e_rv, e_ok, e_hit;
  int e_rd;
  bit e_done [NB];

  task automatic check(input int act, input int exp, input string req, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    started = 1;
    if (cyc > 20000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
    if (rst) begin
      e_rv = 0; e_ok = 0; e_hit = 0; e_rd = 0;
      for (int b = 0; b < NB; b++) begin
        m_val[b] = 0; m_cnt[b] = 0; e_done[b] = 0; m_open[b] = 0;
      end
    end else begin
      bit acc;
      int b;
      bit hm;
      e_rv = cmd_valid; e_ok = 0; e_hit = 0; e_rd = 0;
      if (cmd_valid) begin
        b = int'(cmd_bank);
        hm = m_val[b] && (m_open[b] == int'(cmd_row));
        if (m_cnt[b] == 0) begin
          case (cmd_op)
            2'd0: begin
              e_ok = 1; e_hit = hm;
              if (!m_val[b]) begin
                for (int c = 0; c < COLS; c++) m_buf[b][c] = m_mem[b][cmd_row][c];
                m_val[b] = 1; m_open[b] = int'(cmd_row);
              end else if (!hm) begin
                for (int c = 0; c < COLS; c++) m_mem[b][cmd_row][c] = m_buf[b][c];
                m_open[b] = int'(cmd_row);
              end
            end
            2'd1: if (hm) begin e_ok = 1; e_hit = 1; e_rd = m_buf[b][cmd_col]; end
            2'd2: if (hm) begin
              e_ok = 1; e_hit = 1;
              m_buf[b][cmd_col] = int'(cmd_wdata);
              m_mem[b][m_open[b]][cmd_col] = int'(cmd_wdata);
            end
            default: begin e_ok = 1; m_val[b] = 0; end
          endcase
        end
      end
      acc = req_valid && (m_cnt[int'(req_bank)] == 0);
      for (int k = 0; k < NB; k++) begin
        e_done[k] = 0;
        if (m_cnt[k] > 0) begin
          m_cnt[k]--;
          if (m_cnt[k] == 0) begin
            e_done[k] = 1;
            for (int c = 0; c < COLS; c++) m_mem[k][m_dst[k]][c] = m_mem[k][m_src[k]][c];
            m_val[k] = 0;
          end
        end
      end
      if (acc) begin
        m_cnt[int'(req_bank)] = LAT;
        m_src[int'(req_bank)] = int'(req_src);
        m_dst[int'(req_bank)] = int'(req_dst);
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    #1;
    if (started) begin
      check(int'(rsp_valid), int'(e_rv), tag, "rsp_valid");
      if (e_rv) begin
        check(int'(rsp_ok), int'(e_ok), tag, "rsp_ok");
        check(int'(rsp_hit), int'(e_hit), tag, "rsp_hit");
        check(int'(rsp_rdata), e_rd, tag, "rsp_rdata");
      end
      for (int k = 0; k < NB; k++) begin
        check(int'(copy_busy[k]), int'(m_cnt[k] > 0), "R7", "copy_busy");
        check(int'(copy_done[k]), int'(e_done[k]), "R7", "copy_done");
      end
      check(int'(req_ready), int'(m_cnt[int'(req_bank)] == 0), "R7", "req_ready");
    end
  end

  task automatic do_cmd(input int op, input int b, input int r, input int c, input int w);
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'(op); cmd_bank = 1'(b); cmd_row = 3'(r);
    cmd_col = 2'(c); cmd_wdata = WW'(w); req_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); cmd_valid = 0; req_valid = 0; end
  endtask

  task automatic copy_req(input int b, input int s, input int d);
    @(negedge clk);
    cmd_valid = 0; req_valid = 1; req_bank = 1'(b); req_src = 3'(s); req_dst = 3'(d);
  endtask

  task automatic dump_bank(input int b);
    for (int r = 0; r < ROWS; r++) begin
      do_cmd(0, b, r, 0, 0);
      for (int c = 0; c < COLS; c++) do_cmd(1, b, r, c, 0);
      do_cmd(3, b, r, 0, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: freshly reset bank refuses reads
    do_cmd(1, 0, 0, 0, 0);
    do_cmd(2, 1, 3, 1, 5);
    idle(2);
    // R2: load every row with a distinct pattern
    tag = "R2";
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < ROWS; r++) begin
        do_cmd(0, b, r, 0, 0);
        for (int c = 0; c < COLS; c++) do_cmd(2, b, r, c, (b*97 + r*13 + c*5 + 1) & 255);
        do_cmd(3, b, r, 0, 0);
      end
    do_cmd(0, 1, 3, 0, 0);
    for (int c = 0; c < COLS; c++) do_cmd(1, 1, 3, c, 0);
    // R4: reopen of the open row is a hit
    tag = "R4";
    do_cmd(0, 1, 3, 0, 0);
    do_cmd(1, 1, 3, 2, 0);
    tag = "R6";
    do_cmd(3, 1, 3, 0, 0);
    do_cmd(1, 1, 3, 0, 0);
    // R3: accesses to a row that is not open
    tag = "R3";
    do_cmd(0, 0, 2, 0, 0);
    do_cmd(1, 0, 5, 1, 0);
    do_cmd(2, 0, 5, 1, 8'hEE);
    do_cmd(1, 0, 2, 1, 0);
    do_cmd(3, 0, 0, 0, 0);
    do_cmd(0, 0, 5, 0, 0);
    do_cmd(1, 0, 5, 1, 0);
    do_cmd(3, 0, 0, 0, 0);
    // R5: back-to-back opens clone row 1 into row 6
    tag = "R5";
    do_cmd(0, 0, 1, 0, 0);
    do_cmd(0, 0, 6, 0, 0);
    do_cmd(1, 0, 6, 3, 0);
    do_cmd(3, 0, 0, 0, 0);
    do_cmd(0, 0, 6, 0, 0);
    for (int c = 0; c < COLS; c++) do_cmd(1, 0, 6, c, 0);
    do_cmd(3, 0, 0, 0, 0);
    // R11: interleaved banks
    tag = "R11";
    do_cmd(0, 1, 4, 0, 0);
    do_cmd(0, 0, 0, 0, 0);
    do_cmd(2, 0, 0, 2, 8'h5A);
    do_cmd(1, 1, 4, 2, 0);
    do_cmd(3, 0, 0, 0, 0);
    do_cmd(1, 1, 4, 0, 0);
    do_cmd(3, 1, 0, 0, 0);
    // R7 / R10: copy on bank 0 with a row left open beforehand
    tag = "R10";
    do_cmd(0, 0, 3, 0, 0);
    copy_req(0, 2, 7);
    do_cmd(1, 0, 3, 0, 0);
    do_cmd(0, 0, 4, 0, 0);
    do_cmd(0, 1, 1, 0, 0);
    do_cmd(1, 1, 1, 2, 0);
    do_cmd(3, 1, 0, 0, 0);
    tag = "R7";
    @(negedge clk);
    cmd_valid = 0; req_valid = 1; req_bank = 1'(0); req_src = 3'(0); req_dst = 3'(1);
    @(negedge clk);
    cmd_valid = 0;
    copy_req(1, 0, 5);
    idle(LAT + 3);
    // R8: data after both copies, buffer closed afterwards
    tag = "R8";
    do_cmd(1, 0, 7, 0, 0);
    dump_bank(0);
    dump_bank(1);
    // R9: copy onto itself
    tag = "R9";
    copy_req(1, 5, 5);
    idle(LAT + 2);
    dump_bank(1);
    idle(2);
    summary();
  end
endmodule